// File: doc/BRIEF.md
# Multiplexed Channel Scan Sequencer

This block decides which input a multi-channel converter front end samples next. It holds a small configuration: an enable, a single or paired grouping, a flag that adds a temperature-sensor slot, the index of the final channel, and a channel to park on while scanning is off. Each conversion-complete pulse moves the registered selection one slot forward. The outputs are a channel index, a temperature-select flag and a marker that flags the opening slot of every pass.

A pass always opens at channel 0. In single mode it visits each channel up to the final index. In paired mode it visits even channels, one per adjacent even/odd pair, and ends on the pair that holds the final index. If the temperature slot is enabled, it follows the final channel, and then the pass wraps to channel 0. Loading a configuration restarts the scan. While scanning is disabled the selection stays on the parked channel.

Top module: `scan_seq`

## Requirements
- R1: After a synchronous reset, sel_ch is 0, sel_temp is 0 and sel_first is 0, and the sequencer is disabled with parked channel 0.
- R2: A cfg_load pulse with cfg_enable=1 makes the outputs sel_ch=0, sel_first=1, sel_temp=0 on the next clock edge.
- R3: In single mode (cfg_paired=0), each conv_done pulse raises sel_ch by one, effective on the edge that samples the pulse.
- R4: In single mode, a conv_done pulse while sel_ch equals the final index wraps sel_ch to 0 with sel_first=1, provided the temperature slot is off.
- R5: In paired mode (cfg_paired=1), sel_ch is always even and steps by two. The last slot of a pass is the even channel whose pair holds the final index: final index 5 gives 0, 2, 4, and final index 4 also gives 0, 2, 4.
- R6: With cfg_temp_incl=1, the conversion after the last channel slot gives sel_temp=1, sel_ch=0, sel_first=0. The pulse after that gives channel 0 with sel_first=1.
- R7: sel_first is 1 only on the channel-0 slot that opens a pass, and never together with sel_temp.
- R8: A cfg_load restarts the scan from channel 0 even in the middle of a pass. It takes priority over a conv_done pulse in the same cycle.
- R9: While disabled (cfg_enable=0 at the last load), sel_ch equals the parked channel cfg_hold_ch, sel_temp and sel_first are 0, and conv_done has no effect.
- R10: The outputs change only on a clock edge that samples cfg_load or conv_done.
- R11: With final index 0 in single mode and no temperature slot, every conversion gives channel 0 with sel_first=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle pulse that captures the configuration inputs |
| cfg_enable | input | 1 | 1 to scan, 0 to park on cfg_hold_ch |
| cfg_paired | input | 1 | 0 for single channels, 1 for even/odd pairs |
| cfg_temp_incl | input | 1 | 1 to add a temperature slot after the final channel |
| cfg_last_ch | input | CH_W | Index of the final channel in a pass |
| cfg_hold_ch | input | CH_W | Channel held while disabled |
| conv_done | input | 1 | One-cycle pulse marking the end of a conversion |
| sel_ch | output | CH_W | Selected channel (the even member in paired mode) |
| sel_temp | output | 1 | Temperature-sensor slot selected |
| sel_first | output | 1 | Opening slot of a pass |

## Verification
Every result is due on exactly the clock edge that samples its cfg_load or conv_done pulse, because the selection is a single register stage with no pipeline. The bench drives each pulse on a falling edge and holds it across one rising edge. It then compares the outputs on the next falling edge, half a period after that update. Hold checks wait several idle cycles and compare again, which confirms that nothing moves without a pulse.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_PAIR   = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/scan_cfg_reg.sv
module scan_cfg_reg
  import scan_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            d_en,
  input  logic            d_pair,
  input  logic            d_temp,
  input  logic [CH_W-1:0] d_last,
  input  logic [CH_W-1:0] d_hold,
  output logic            q_en,
  output scan_mode_e      q_mode,
  output logic            q_temp,
  output logic [CH_W-1:0] q_last,
  output logic [CH_W-1:0] q_hold
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_en   <= 1'b0;
      q_mode <= MODE_SINGLE;
      q_temp <= 1'b0;
      q_last <= '0;
      q_hold <= '0;
    end else if (load) begin
      q_en   <= d_en;
      q_mode <= d_pair ? MODE_PAIR : MODE_SINGLE;
      q_temp <= d_temp;
      q_last <= d_last;
      q_hold <= d_hold;
    end
  end
endmodule

// File: rtl/scan_next.sv
module scan_next
  import scan_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            cur_temp,
  input  logic [CH_W-1:0] cur_ch,
  input  scan_mode_e      mode,
  input  logic            temp_en,
  input  logic [CH_W-1:0] last,
  output logic            nxt_temp,
  output logic [CH_W-1:0] nxt_ch,
  output logic            nxt_first
);
  localparam logic [CH_W-1:0] ONE = CH_W'(1);
  localparam logic [CH_W-1:0] TWO = CH_W'(2);

  logic            at_end;
  logic [CH_W-1:0] step;

  always_comb begin
    step   = (mode == MODE_PAIR) ? TWO : ONE;
    at_end = (mode == MODE_PAIR) ? ((cur_ch | ONE) >= last) : (cur_ch >= last);
    nxt_temp  = 1'b0;
    nxt_ch    = '0;
    nxt_first = 1'b0;
    if (cur_temp) begin
      nxt_first = 1'b1;
    end else if (at_end) begin
      if (temp_en) nxt_temp  = 1'b1;
      else         nxt_first = 1'b1;
    end else begin
      nxt_ch = cur_ch + step;
    end
  end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_load,
  input  logic            cfg_enable,
  input  logic            cfg_paired,
  input  logic            cfg_temp_incl,
  input  logic [CH_W-1:0] cfg_last_ch,
  input  logic [CH_W-1:0] cfg_hold_ch,
  input  logic            conv_done,
  output logic [CH_W-1:0] sel_ch,
  output logic            sel_temp,
  output logic            sel_first
);
  logic            en_q;
  scan_mode_e      mode_q;
  logic            temp_q;
  logic [CH_W-1:0] last_q;
  logic [CH_W-1:0] hold_q;

  logic            nxt_temp;
  logic [CH_W-1:0] nxt_ch;
  logic            nxt_first;

  scan_cfg_reg #(.CH_W(CH_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .load   (cfg_load),
    .d_en   (cfg_enable),
    .d_pair (cfg_paired),
    .d_temp (cfg_temp_incl),
    .d_last (cfg_last_ch),
    .d_hold (cfg_hold_ch),
    .q_en   (en_q),
    .q_mode (mode_q),
    .q_temp (temp_q),
    .q_last (last_q),
    .q_hold (hold_q)
  );

  scan_next #(.CH_W(CH_W)) u_next (
    .cur_temp  (sel_temp),
    .cur_ch    (sel_ch),
    .mode      (mode_q),
    .temp_en   (temp_q),
    .last      (last_q),
    .nxt_temp  (nxt_temp),
    .nxt_ch    (nxt_ch),
    .nxt_first (nxt_first)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ch    <= '0;
      sel_temp  <= 1'b0;
      sel_first <= 1'b0;
    end else if (cfg_load) begin
      sel_ch    <= cfg_enable ? '0 : cfg_hold_ch;
      sel_temp  <= 1'b0;
      sel_first <= cfg_enable;
    end else if (conv_done && en_q) begin
      sel_ch    <= nxt_ch;
      sel_temp  <= nxt_temp;
      sel_first <= nxt_first;
    end
  end

  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load && cfg_enable |=> sel_first && (sel_ch == '0) && !sel_temp);

  // R9
  park_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load && !cfg_enable |=> (sel_ch == $past(cfg_hold_ch)) && !sel_temp && !sel_first);

  // R9
  park_stay_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q && !cfg_load |=> (sel_ch == hold_q) && !sel_temp && !sel_first);

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_load && !conv_done |=> $stable(sel_ch) && $stable(sel_temp) && $stable(sel_first));

  // R7
  first_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sel_first |-> (sel_ch == '0) && !sel_temp);

  // R6
  temp_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    sel_temp && conv_done && !cfg_load |=> sel_first && (sel_ch == '0));

  // R5
  pair_even_chk: assert property (@(posedge clk) disable iff (rst)
    en_q && (mode_q == MODE_PAIR) |-> !sel_ch[0]);

  // R4
  range_chk: assert property (@(posedge clk) disable iff (rst)
    en_q && !sel_temp |-> sel_ch <= last_q);
endmodule

// File: tb/sim_scan_seq.sv
module sim_scan_seq;
  localparam int CH_W = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_load = 1'b0;
  logic            cfg_enable = 1'b0;
  logic            cfg_paired = 1'b0;
  logic            cfg_temp_incl = 1'b0;
  logic [CH_W-1:0] cfg_last_ch = '0;
  logic [CH_W-1:0] cfg_hold_ch = '0;
  logic            conv_done = 1'b0;
  logic [CH_W-1:0] sel_ch;
  logic            sel_temp;
  logic            sel_first;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  scan_seq #(.CH_W(CH_W)) u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_enable(cfg_enable),
    .cfg_paired(cfg_paired), .cfg_temp_incl(cfg_temp_incl),
    .cfg_last_ch(cfg_last_ch), .cfg_hold_ch(cfg_hold_ch),
    .conv_done(conv_done), .sel_ch(sel_ch), .sel_temp(sel_temp),
    .sel_first(sel_first)
  );

  task automatic expect_out(string tag, int ch, int tmp, int fst);
    n_tests++;
    if (int'(sel_ch) != ch || int'(sel_temp) != tmp || int'(sel_first) != fst) begin
      n_fail++;
      $display("FAIL %s: got ch=%0d temp=%0d first=%0d, expected ch=%0d temp=%0d first=%0d",
               tag, sel_ch, sel_temp, sel_first, ch, tmp, fst);
    end
  endtask

  task automatic load_cfg(logic en, logic pr, logic tp, int last, int hold);
    @(negedge clk);
    cfg_enable = en; cfg_paired = pr; cfg_temp_incl = tp;
    cfg_last_ch = CH_W'(last); cfg_hold_ch = CH_W'(hold);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic conv();
    @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 0, 0, 0);
    conv();
    expect_out("R1 reset conv ignored", 0, 0, 0);
  endtask

  task automatic t_single();
    load_cfg(1'b1, 1'b0, 1'b0, 3, 0);
    expect_out("R2 start", 0, 0, 1);
    conv(); expect_out("R3 step1", 1, 0, 0);
    repeat (3) @(negedge clk);
    expect_out("R10 hold", 1, 0, 0);
    conv(); expect_out("R3 step2", 2, 0, 0);
    conv(); expect_out("R3 step3", 3, 0, 0);
    conv(); expect_out("R4 wrap", 0, 0, 1);
    conv(); expect_out("R7 first only at pass start", 1, 0, 0);
  endtask

  task automatic t_pair();
    load_cfg(1'b1, 1'b1, 1'b0, 5, 0);
    expect_out("R5 pair last5 start", 0, 0, 1);
    conv(); expect_out("R5 pair last5 s2", 2, 0, 0);
    conv(); expect_out("R5 pair last5 s4", 4, 0, 0);
    conv(); expect_out("R5 pair last5 wrap", 0, 0, 1);
    load_cfg(1'b1, 1'b1, 1'b0, 4, 0);
    conv(); expect_out("R5 pair last4 s2", 2, 0, 0);
    conv(); expect_out("R5 pair last4 s4", 4, 0, 0);
    conv(); expect_out("R5 pair last4 wrap", 0, 0, 1);
  endtask

  task automatic t_temp();
    load_cfg(1'b1, 1'b0, 1'b1, 2, 0);
    conv(); expect_out("R6 single ch1", 1, 0, 0);
    conv(); expect_out("R6 single ch2", 2, 0, 0);
    conv(); expect_out("R6 temp slot", 0, 1, 0);
    conv(); expect_out("R6 wrap after temp", 0, 0, 1);
    load_cfg(1'b1, 1'b1, 1'b1, 1, 0);
    conv(); expect_out("R6 pair temp slot", 0, 1, 0);
    conv(); expect_out("R6 pair wrap", 0, 0, 1);
  endtask

  task automatic t_restart();
    load_cfg(1'b1, 1'b0, 1'b0, 7, 0);
    conv(); conv(); conv();
    expect_out("R8 mid-scan", 3, 0, 0);
    load_cfg(1'b1, 1'b0, 1'b0, 7, 0);
    expect_out("R8 restart", 0, 0, 1);
    conv(); conv();
    @(negedge clk);
    cfg_load = 1'b1; conv_done = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0; conv_done = 1'b0;
    expect_out("R8 load beats conv", 0, 0, 1);
  endtask

  task automatic t_disabled();
    load_cfg(1'b0, 1'b0, 1'b1, 7, 5);
    expect_out("R9 park", 5, 0, 0);
    conv(); conv(); conv();
    expect_out("R9 conv ignored", 5, 0, 0);
  endtask

  task automatic t_last0();
    load_cfg(1'b1, 1'b0, 1'b0, 0, 0);
    conv(); expect_out("R11 last0 a", 0, 0, 1);
    conv(); expect_out("R11 last0 b", 0, 0, 1);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_pair();
    t_temp();
    t_restart();
    t_disabled();
    t_last0();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule